// File: doc/BRIEF.md
# I2C Write-Only Target with Strapped Subaddress Select

This block is a receive-only target on a two-wire serial bus. It samples the clock and data lines into its own clock domain and finds bus START and STOP conditions. It shifts in 8-bit bytes and pulls the data line low during the ninth clock of each byte to acknowledge it. It never starts a transfer and never returns data.

A transfer opens with an address byte. If the 7-bit address matches the parameter `DEV_ADDR` and the direction bit asks for a write, the block acknowledges that byte and every byte that follows, with no limit on their number.

Several identical devices can share one bus address. Each one carries a three-pin hardware subaddress. A device-select command in the byte stream names one subaddress. Only the device whose pins match it sets its `selected` flag and passes later data bytes to the core logic on a one-cycle valid strobe.

Top module: `i2c_subsel_rx`

## Requirements
- R1: A START is a falling data line while the clock line is high. A STOP is a rising data line while the clock line is high. A START, including a repeated START, always restarts framing with a fresh address byte.
- R2: After an address byte whose upper seven bits equal `DEV_ADDR` and whose least significant bit is 0 (write), `sda_oe` is 1 across the whole ninth clock-high period. The line then reads low there.
- R3: After an address byte that does not match, or whose least significant bit is 1 (read), the block acknowledges no byte and emits no byte until the next START.
- R4: Once addressed for write, the block acknowledges every byte of the transfer, however many there are.
- R5: A select command is a byte whose upper five bits are 11100. It sets `selected` when its lower three bits equal `sub_pins`, and clears it otherwise. The command byte itself is never emitted.
- R6: Any other byte of an addressed transfer appears on `rx_data` with a one-cycle `rx_valid` pulse, but only while `selected` is 1.
- R7: `selected` keeps its value across STOP and START conditions. It changes only on a select command or on reset.
- R8: A STOP or START that arrives during a partial byte discards that byte. A STOP also leaves `sda_oe` at 0 and returns the block to idle.
- R9: While reset is asserted, `sda_oe`, `rx_valid` and `selected` are all 0.
- R10: `sda_oe` changes only while the sampled clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sub_pins | input | 3 | Strapped hardware subaddress, 0 to 7 |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain), 0 releases it |
| rx_data | output | 8 | Last emitted data byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| selected | output | 1 | Device is currently chosen by a select command |

## Verification
Bit capture and condition detection both act while the clock line is high, so they can fall in the same window. The bench provokes this in two ways. In one transfer, a STOP follows a few captured bits of a data byte. In another, a repeated START is placed in the middle of a byte. Each case is judged by three outcomes: no strobe appears for the partial byte, the data line is found released, and the address that follows is acknowledged and its data byte reaches the scoreboard intact.

// File: rtl/i2csr_pkg.sv
package i2csr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2csr_line_sync.sv
module i2csr_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic scl_old_q, sda_old_q;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
  end

  // idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_old_q  <= 1'b1;
      sda_old_q  <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_old_q  <= scl_pipe_q[SYNC_STAGES-1];
      sda_old_q  <= sda_pipe_q[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe_q[SYNC_STAGES-1];
  assign sda_lvl   = sda_pipe_q[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_old_q;
  assign scl_fall  = ~scl_lvl & scl_old_q;
  assign start_det = scl_lvl & scl_old_q & sda_old_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_old_q & ~sda_old_q & sda_lvl;
endmodule

// File: rtl/i2csr_frame_fsm.sv
module i2csr_frame_fsm
  import i2csr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              ack_oe,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == DEV_ADDR) && !sh_q[0];

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    byte_stb = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == FULL) begin
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                oe_d    = 1'b1;
                state_d = ST_ACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else begin
              byte_stb = 1'b1;
              oe_d     = 1'b1;
              state_d  = ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
    end
  end

  assign ack_oe   = oe_q;
  assign byte_val = sh_q;

  // R10
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |-> !scl_lvl);
  // R10
  oe_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(stop_det) && !$past(start_det))
      |-> $stable(ack_oe));
  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !ack_oe);
  // R4
  data_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> ack_oe);
endmodule

// File: rtl/i2csr_sel_filter.sv
module i2csr_sel_filter
  import i2csr_pkg::*;
#(
  parameter int SUB_W = 3,
  parameter logic [BYTE_W-SUB_W-1:0] SEL_TAG = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [SUB_W-1:0]  sub_pins,
  output logic              sel_flag,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data
);
  logic              sel_q, sel_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] data_q;
  logic              tag_hit, load_en;

  assign tag_hit = byte_val[BYTE_W-1:SUB_W] == SEL_TAG;

  always_comb begin
    sel_d   = sel_q;
    vld_d   = 1'b0;
    load_en = 1'b0;
    if (byte_stb) begin
      if (tag_hit) begin
        sel_d = (byte_val[SUB_W-1:0] == sub_pins);
      end else if (sel_q) begin
        vld_d   = 1'b1;
        load_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      sel_q <= sel_d;
      vld_q <= vld_d;
      if (load_en) data_q <= byte_val;
    end
  end

  assign sel_flag = sel_q;
  assign rx_valid = vld_q;
  assign rx_data  = data_q;

  // R6
  emit_when_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sel_q));
  // R5
  cmd_not_emitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && tag_hit) |=> !rx_valid);
endmodule

// File: rtl/i2c_subsel_rx.sv
module i2c_subsel_rx #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h3A,
  parameter int SUB_W = 3,
  parameter logic [8-SUB_W-1:0] SEL_TAG = 5'b11100,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SUB_W-1:0] sub_pins,
  output logic             sda_oe,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             selected
);
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic       byte_stb;
  logic [7:0] byte_val;

  i2csr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2csr_frame_fsm #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .ack_oe(sda_oe), .byte_stb(byte_stb),
    .byte_val(byte_val)
  );

  i2csr_sel_filter #(.SUB_W(SUB_W), .SEL_TAG(SEL_TAG)) u_sel (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
    .sub_pins(sub_pins), .sel_flag(selected), .rx_valid(rx_valid),
    .rx_data(rx_data)
  );
endmodule

// File: tb/i2c_subsel_rx_bench.sv
`timescale 1ns/1ps
module i2c_subsel_rx_bench;
  localparam int QNS = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] sub = 3'd5;
  logic       sda_oe, rx_valid, selected;
  logic [7:0] rx_data;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  i2c_subsel_rx u_i2c_subsel_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sub_pins(sub), .sda_oe(sda_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .selected(selected)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every strobe (R6)
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected byte", int'(rx_data), -1);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(rx_data == e, "R6", "emitted byte", int'(rx_data), int'(e));
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; #QNS; scl_m = 1'b1; #QNS;
    sda_m = 1'b0; #QNS; scl_m = 1'b0; #QNS;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #QNS; scl_m = 1'b1; #QNS;
    sda_m = 1'b1; #(4*QNS);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; #QNS; scl_m = 1'b1; #(2*QNS); scl_m = 1'b0; #QNS;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                           input string req);
    logic lo_a, lo_b;
    send_bits(b, 8);
    sda_m = 1'b1; #QNS; scl_m = 1'b1;
    #4; lo_a = ~sda_line;
    #(2*QNS - 8); lo_b = ~sda_line;
    #4; scl_m = 1'b0; #QNS;
    check((lo_a & lo_b) == exp_ack && (lo_a | lo_b) == exp_ack, req,
          "ack on ninth clock", int'(lo_a & lo_b), int'(exp_ack));
  endtask

  task automatic send_data(input logic [7:0] b, input bit emit);
    if (emit) exp_q.push_back(b);
    send_byte(b, 1'b1, "R4");
  endtask

  task automatic drain(input string req);
    #(20*QNS);
    check(exp_q.size() == 0, req, "scoreboard empty", exp_q.size(), 0);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    #40;
    // R9 reset state
    check(sda_oe == 1'b0, "R9", "sda_oe in reset", sda_oe, 0);
    check(rx_valid == 1'b0, "R9", "rx_valid in reset", rx_valid, 0);
    check(selected == 1'b0, "R9", "selected in reset", selected, 0);
    #1 rst_n = 1'b1;
    #(4*QNS);

    // R2 address ack; no select yet, data acked but not passed on
    bus_start();
    send_byte({7'h3A, 1'b0}, 1'b1, "R2");
    send_data(8'h55, 1'b0);
    bus_stop();
    check(sda_oe == 1'b0, "R8", "released after stop", sda_oe, 0);
    check(selected == 1'b0, "R7", "selected still clear", selected, 0);

    // R5 select our subaddress, then a long run of bytes (R4, R6)
    bus_start();
    send_byte({7'h3A, 1'b0}, 1'b1, "R2");
    send_byte(8'hE5, 1'b1, "R5");
    check(selected == 1'b1, "R5", "selected after match", selected, 1);
    for (int i = 0; i < 20; i++) send_data(8'(i * 7 + 1), 1'b1);
    bus_stop();
    drain("R6");
    check(selected == 1'b1, "R7", "selected kept over stop", selected, 1);

    // R3 wrong address
    bus_start();
    send_byte({7'h3B, 1'b0}, 1'b0, "R3");
    send_byte(8'h11, 1'b0, "R3");
    bus_stop();

    // R3 read direction
    bus_start();
    send_byte({7'h3A, 1'b1}, 1'b0, "R3");
    send_byte(8'h22, 1'b0, "R3");
    bus_stop();
    drain("R3");

    // R7 selection persists into new transfer; R5 deselect
    bus_start();
    send_byte({7'h3A, 1'b0}, 1'b1, "R2");
    send_data(8'h42, 1'b1);
    send_byte(8'hE2, 1'b1, "R5");
    check(selected == 1'b0, "R5", "deselected on mismatch", selected, 0);
    send_data(8'h43, 1'b0);
    bus_stop();
    drain("R6");

    // R8 stop in the middle of a byte
    bus_start();
    send_byte({7'h3A, 1'b0}, 1'b1, "R2");
    send_byte(8'hE5, 1'b1, "R5");
    send_bits(8'hA0, 4);
    bus_stop();
    check(sda_oe == 1'b0, "R8", "released after abort", sda_oe, 0);
    drain("R8");
    bus_start();
    send_byte({7'h3A, 1'b0}, 1'b1, "R8");
    send_data(8'h66, 1'b1);
    bus_stop();

    // R1 repeated start mid-byte
    bus_start();
    send_byte({7'h3A, 1'b0}, 1'b1, "R2");
    send_bits(8'hC3, 3);
    bus_start();
    send_byte({7'h3A, 1'b0}, 1'b1, "R1");
    send_data(8'h77, 1'b1);
    bus_stop();
    drain("R1");

    // R5 subaddress zero
    sub = 3'd0;
    bus_start();
    send_byte({7'h3A, 1'b0}, 1'b1, "R2");
    send_byte(8'hE0, 1'b1, "R5");
    check(selected == 1'b1, "R5", "subaddress 0 match", selected, 1);
    send_data(8'h09, 1'b1);
    bus_stop();
    drain("R6");

    finish_up();
  end
endmodule